// File: doc/BRIEF.md
# Dedicated Input and Clock Pin Conditioning Cell

This block sits between a dedicated input pin and the internal routing fabric. It hands the pin value to the fabric in one of four forms: straight through, registered once, registered twice, or through a level-sensitive latch. The capture element is timed by one of the device's synchronous input clocks. The mode and the clock are chosen by static configuration inputs.

When the pin is clock-capable (parameter `CLK_CAPABLE` = 1), the raw pin value also feeds the device clock network. Each logic block receives its own copy, and each copy has its own polarity. When the parameter is 0, those outputs are tied low. The configuration is meant to be set once. The pad itself and the global clock tree are not part of this block.

Top module: `pin_input_cell`

## Requirements
- R1: With `cfg_mode` = 2'b00 (combinational), `fabric_out` equals `pin_in` at all times, with no clock edge needed.
- R2: With `cfg_mode` = 2'b01 (registered), `fabric_out` shows the `pin_in` value sampled at the most recent rising edge of the selected clock.
- R3: With `cfg_mode` = 2'b10 (double-registered), `fabric_out` shows the `pin_in` value sampled two selected-clock rising edges earlier.
- R4: With `cfg_mode` = 2'b11 (latched), `fabric_out` follows `pin_in` while the selected clock is high. While that clock is low, it holds the value present at the falling edge.
- R5: `cfg_clk_sel` = i selects `dev_clk[i]` as the capture clock. Edges on any other `dev_clk` bit leave `fabric_out` unchanged.
- R6: `rst_n` low across a rising edge of the selected clock clears both register stages. `rst_n` low while the selected clock is high clears the latch. After release, `fabric_out` is 0 in modes 2'b01, 2'b10 and 2'b11 until new data is captured. Mode 2'b00 is unaffected.
- R7: With `CLK_CAPABLE` = 1, `clk_out[b]` equals `pin_in` XOR `cfg_clk_inv[b]` for every logic block b. Bit b of the inversion vector inverts only copy b.
- R8: With `CLK_CAPABLE` = 0, every bit of `clk_out` is 0 whatever `pin_in` and `cfg_clk_inv` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low reset, sampled on the selected capture clock |
| dev_clk | input | NUM_CLK | Device synchronous input clocks |
| pin_in | input | 1 | Value arriving from the input pad |
| cfg_mode | input | 2 | Delivery mode: 00 combinational, 01 registered, 10 double-registered, 11 latched |
| cfg_clk_sel | input | SEL_W | Index of the capture clock in `dev_clk` |
| cfg_clk_inv | input | NUM_BLK | Per-logic-block clock polarity; 1 inverts that copy |
| fabric_out | output | 1 | Conditioned pin value toward the interconnect |
| clk_out | output | NUM_BLK | Polarity-adjusted clock copies, one per logic block |

## Verification
The hardest situation to reach from the ports is the latch behaving correctly in both phases of a single capture pulse. It must be transparent while the clock is high, which means it has to track a pin change made inside the high phase. After the fall it must hold, which means it has to ignore a pin change made just after the clock drops. The stimulus hand-drives every device clock as a separate pulse, which opens windows where exactly one clock is high. Within such a window the bench flips the pin and checks the output. It flips the pin again once the clock has dropped and checks that the output held. The same sweep pulses every unselected clock between selected edges, so that a wrong clock choice shows up for each mode/clock pair.

// File: rtl/pin_cell_pkg.sv
// Package: shared types for the input/clock pin conditioning cell.
// Assumes the mode field is a 2-bit static configuration value.
package pin_cell_pkg;

    // Delivery modes of the pin value toward the fabric.
    typedef enum logic [1:0] {
        PIN_COMB  = 2'b00,
        PIN_REG   = 2'b01,
        PIN_DREG  = 2'b10,
        PIN_LATCH = 2'b11
    } pin_mode_e;

endpackage

// File: rtl/pin_clk_select.sv
// Module: pin_clk_select
// Picks one of NUM_CLK device clocks as the capture clock.
// Assumes the select changes only while all device clocks are low,
// so the selected clock never glitches.
module pin_clk_select #(
    parameter int NUM_CLK = 4,
    localparam int SEL_W  = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
    input  logic [NUM_CLK-1:0] dev_clk,
    input  logic [SEL_W-1:0]   clk_sel,
    output logic               cap_clk
);

    // AND-OR selection of the capture clock from the device clocks.
    always_comb begin
        cap_clk = 1'b0;
        for (int i = 0; i < NUM_CLK; i++) begin
            cap_clk = cap_clk | ((clk_sel == SEL_W'(i)) & dev_clk[i]);
        end
    end

endmodule

// File: rtl/pin_capture_stages.sv
// Module: pin_capture_stages
// Holds the storage elements of the cell: two cascaded flops and a
// level-sensitive latch, all timed by the capture clock. Every element runs
// in every mode; the mode only chooses which one reaches the fabric.
// Assumes synchronous active-low reset sampled on the capture clock.
module pin_capture_stages
    import pin_cell_pkg::*;
(
    input  logic      cap_clk,
    input  logic      rst_n,
    input  logic      pin_in,
    input  pin_mode_e mode,
    output logic      fabric_out
);

    logic stage1_q;
    logic stage2_q;
    logic latch_q;

    // First capture flop: samples the pin on each rising capture edge.
    always_ff @(posedge cap_clk) begin
        if (!rst_n) begin
            stage1_q <= 1'b0;
        end else begin
            stage1_q <= pin_in;
        end
    end

    // Second flop: delays the first stage by one capture edge.
    always_ff @(posedge cap_clk) begin
        if (!rst_n) begin
            stage2_q <= 1'b0;
        end else begin
            stage2_q <= stage1_q;
        end
    end

    // Latch: transparent while the capture clock is high, cleared if reset then.
    always_latch begin
        if (cap_clk) begin
            latch_q = rst_n ? pin_in : 1'b0;
        end
    end

    // Output selection according to the delivery mode.
    always_comb begin
        unique case (mode)
            PIN_COMB:  fabric_out = pin_in;
            PIN_REG:   fabric_out = stage1_q;
            PIN_DREG:  fabric_out = stage2_q;
            PIN_LATCH: fabric_out = latch_q;
            default:   fabric_out = pin_in;
        endcase
    end

endmodule

// File: rtl/pin_clk_fanout.sv
// Module: pin_clk_fanout
// Produces one polarity-adjusted clock copy per logic block from the pin.
// When the pin is not clock-capable, all copies are tied low.
// Assumes the inversion vector is static while the copies are in use.
module pin_clk_fanout #(
    parameter int NUM_BLK     = 4,
    parameter bit CLK_CAPABLE = 1'b1
) (
    input  logic               pin_in,
    input  logic [NUM_BLK-1:0] clk_inv,
    output logic [NUM_BLK-1:0] clk_out
);

    generate
        if (CLK_CAPABLE) begin : g_capable
            for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
                // Polarity control for the copy sent to logic block b.
                always_comb begin
                    clk_out[b] = clk_inv[b] ? ~pin_in : pin_in;
                end
            end
        end else begin : g_plain
            logic unused_in;
            // No clock role: the copies stay low and the inputs are unused.
            always_comb begin
                unused_in = pin_in ^ (^clk_inv);
                clk_out   = '0;
            end
        end
    endgenerate

endmodule

// File: rtl/pin_input_cell.sv
// Module: pin_input_cell (top)
// Conditioning cell for a dedicated input or input/clock pin. It delivers the
// pin to the fabric combinationally, registered, double-registered or
// latched, on a capture clock chosen from the device clocks. It also drives
// polarity-controlled clock copies when the pin is clock-capable.
// Assumes static configuration, changed only while all device clocks are low.
module pin_input_cell
    import pin_cell_pkg::*;
#(
    parameter int NUM_CLK     = 4,
    parameter int NUM_BLK     = 4,
    parameter bit CLK_CAPABLE = 1'b1,
    localparam int SEL_W      = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
    input  logic               rst_n,
    input  logic [NUM_CLK-1:0] dev_clk,
    input  logic               pin_in,
    input  logic [1:0]         cfg_mode,
    input  logic [SEL_W-1:0]   cfg_clk_sel,
    input  logic [NUM_BLK-1:0] cfg_clk_inv,
    output logic               fabric_out,
    output logic [NUM_BLK-1:0] clk_out
);

    logic      cap_clk;
    pin_mode_e mode;

    // Decode the raw mode field into the typed mode.
    always_comb begin
        mode = pin_mode_e'(cfg_mode);
    end

    pin_clk_select #(
        .NUM_CLK (NUM_CLK)
    ) u_sel (
        .dev_clk (dev_clk),
        .clk_sel (cfg_clk_sel),
        .cap_clk (cap_clk)
    );

    pin_capture_stages u_cap (
        .cap_clk    (cap_clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .mode       (mode),
        .fabric_out (fabric_out)
    );

    pin_clk_fanout #(
        .NUM_BLK     (NUM_BLK),
        .CLK_CAPABLE (CLK_CAPABLE)
    ) u_fan (
        .pin_in  (pin_in),
        .clk_inv (cfg_clk_inv),
        .clk_out (clk_out)
    );

endmodule

// File: rtl/pin_input_cell_chk.sv
// Module: pin_input_cell_chk
// Assertion checker for pin_input_cell, bound to every instance of it.
// The properties are timed by the cell's selected capture clock.
module pin_input_cell_chk (
    input logic       rst_n,
    input logic       cap_clk,
    input logic [1:0] mode,
    input logic       pin,
    input logic       fabric
);

    // R1: the combinational mode shows the pin at every capture edge.
    a_r1_comb_follows: assert property (@(posedge cap_clk) disable iff (!rst_n)
        (mode == 2'b00) |-> (fabric == pin));

    // R2: the registered mode shows the pin from the previous capture edge.
    a_r2_reg_one_edge: assert property (@(posedge cap_clk) disable iff (!rst_n)
        (mode == 2'b01) |=> ((mode != 2'b01) || (fabric == $past(pin))));

    // R3: the double-registered mode shows the pin from two edges back.
    a_r3_dreg_two_edges: assert property (@(posedge cap_clk) disable iff (!rst_n)
        ((mode == 2'b10) && $past(rst_n)) |=> ((mode != 2'b10) || (fabric == $past(pin, 2))));

    // R4: the latched mode is transparent just before the falling edge.
    a_r4_latch_open: assert property (@(negedge cap_clk) disable iff (!rst_n)
        (mode == 2'b11) |-> (fabric == pin));

endmodule

bind pin_input_cell pin_input_cell_chk u_chk (
    .rst_n   (rst_n),
    .cap_clk (cap_clk),
    .mode    (cfg_mode),
    .pin     (pin_in),
    .fabric  (fabric_out)
);

// File: tb/pin_input_cell_bench.sv
// Bench for pin_input_cell. It pulses each device clock by hand, sweeps
// every mode and clock choice, and tracks expected values from the
// requirements.
module pin_input_cell_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCLK       = 4;
    localparam int NBLK       = 4;

    logic            rst_n;
    logic [NCLK-1:0] dev_clk;
    logic            pin;
    logic [1:0]      mode;
    logic [1:0]      sel;
    logic [NBLK-1:0] inv;
    logic            fabric;
    logic [NBLK-1:0] clk_out;
    logic            fabric_nc;
    logic [NBLK-1:0] clk_out_nc;

    int checks   = 0;
    int failures = 0;

    // Expected-state model taken from the requirements.
    logic e1, e2, held;

    pin_input_cell #(.NUM_CLK(NCLK), .NUM_BLK(NBLK), .CLK_CAPABLE(1'b1)) u_pin_input_cell (
        .rst_n(rst_n), .dev_clk(dev_clk), .pin_in(pin), .cfg_mode(mode),
        .cfg_clk_sel(sel), .cfg_clk_inv(inv), .fabric_out(fabric), .clk_out(clk_out)
    );

    pin_input_cell #(.NUM_CLK(NCLK), .NUM_BLK(NBLK), .CLK_CAPABLE(1'b0)) u_pin_input_cell_nc (
        .rst_n(rst_n), .dev_clk(dev_clk), .pin_in(pin), .cfg_mode(mode),
        .cfg_clk_sel(sel), .cfg_clk_inv(inv), .fabric_out(fabric_nc), .clk_out(clk_out_nc)
    );

    task automatic chk(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s mode=%0d sel=%0d actual=%0h expected=%0h", req, mode, sel, act, exp);
        end
    endtask

    function automatic logic expect_out();
        case (mode)
            2'b00:   return pin;
            2'b01:   return e1;
            2'b10:   return e2;
            default: return held;
        endcase
    endfunction

    // One clock pulse on dev_clk[i]; the latch is probed inside the high phase.
    task automatic pulse(input int i);
        bit is_sel = (i == int'(sel));
        #(CLK_PERIOD/4);
        dev_clk[i] = 1'b1;
        if (is_sel) begin
            if (!rst_n) begin
                e1 = 1'b0; e2 = 1'b0; held = 1'b0;
            end else begin
                e2 = e1; e1 = pin;
            end
        end
        #(CLK_PERIOD/4);
        if (is_sel && rst_n && mode == 2'b11) begin
            chk(fabric == pin, "R4 open", 4'(fabric), 4'(pin));
            pin = ~pin;
            #1;
            chk(fabric == pin, "R4 tracks", 4'(fabric), 4'(pin));
        end
        #(CLK_PERIOD/4);
        if (is_sel && rst_n) held = pin;
        dev_clk[i] = 1'b0;
        #(CLK_PERIOD/4);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] pattern;
        rst_n   = 1'b0;
        dev_clk = '0;
        pin     = 1'b0;
        mode    = 2'b00;
        sel     = 2'd0;
        inv     = '0;
        e1 = 1'b0; e2 = 1'b0; held = 1'b0;
        pattern = 8'b1011_0010;

        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < NCLK; s++) begin
                mode  = 2'(m);
                sel   = 2'(s);
                pin   = 1'b1;
                rst_n = 1'b0;
                pulse(s);
                pulse(s);
                #1;
                rst_n = 1'b1;
                #1;
                // R6: reset clears storage; comb mode still follows the pin.
                chk(fabric == ((m == 0) ? pin : 1'b0), "R6 reset", 4'(fabric),
                    4'((m == 0) ? pin : 1'b0));
                for (int k = 0; k < 8; k++) begin
                    pin = pattern[(k + s) % 8];
                    #1;
                    chk(fabric == expect_out(), "R1/R4 idle", 4'(fabric), 4'(expect_out()));
                    for (int j = 0; j < NCLK; j++) begin
                        if (j != s) begin
                            pulse(j);
                            chk(fabric == expect_out(), "R5 other clock", 4'(fabric),
                                4'(expect_out()));
                        end
                    end
                    pulse(s);
                    chk(fabric == expect_out(),
                        (m == 1) ? "R2 reg" : (m == 2) ? "R3 dreg" : (m == 3) ? "R4 held" : "R1 comb",
                        4'(fabric), 4'(expect_out()));
                    if (m == 3) begin
                        pin = ~pin;
                        #1;
                        chk(fabric == held, "R4 hold low", 4'(fabric), 4'(held));
                    end
                end
            end
        end

        // R7 and R8: clock copies and their polarity, capable and not.
        for (int v = 0; v < 16; v++) begin
            for (int p = 0; p < 2; p++) begin
                inv = 4'(v);
                pin = p[0];
                #1;
                chk(clk_out == (p[0] ? ~4'(v) : 4'(v)), "R7 polarity", clk_out,
                    p[0] ? ~4'(v) : 4'(v));
                chk(clk_out_nc == 4'h0, "R8 tied low", clk_out_nc, 4'h0);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule